// File: doc/BRIEF.md
# Serial FIR-and-XOR byte pipeline

This block takes a one-bit serial stream, packs every eight bits into a byte, smooths the byte with a fixed four-tap integer filter, scrambles the result with a constant XOR mask and sends it back out serially. A completion strobe follows each byte. One sequencing state machine handles one byte at a time. Its phases are receive, filter, mask, transmit and done. Receive and transmit never overlap, so a new byte is accepted only after the previous one has left.

The filter weights the newest byte and the three bytes before it as 1-2-2-1 and divides by four. It keeps its history across bytes. The history is cleared only by reset, so the first bytes after reset are smoothed against zeros. An enable input freezes the pipeline in an idle state and silences the outputs. The sender must place the first bit on the line one clock after enable is seen high.

Top module: `ser_fir_xor_pipe`

## Requirements
- R1: In receive, `ser_i` is sampled on each of 8 consecutive rising edges. The first sampled bit becomes bit 0 of the byte and the eighth becomes bit 7. After the eighth bit the machine enters the filter phase.
- R2: The filter result is ((x0 + 2·x1 + 2·x2 + x3) >> 2), formed at 11 bits, with only bits 7:0 kept. x0 is the new byte and x1..x3 are the three previous bytes. For example, four bytes of 0xFF give 0x7E.
- R3: The history shifts by one byte per filtered byte, with the new byte becoming x1 for the next one. It is all zero after reset and is kept while enable is low.
- R4: The filter result is XORed with 0xA5 in the mask phase. The mask phase takes one clock and follows the one-clock filter phase.
- R5: The masked byte appears on `ser_o` MSB first, one bit per clock. Bit 7 is valid in the clock following the second edge after the eighth received bit.
- R6: `done_o` is high for exactly one clock, right after the transmit clock that carried bit 0. The next edge returns the machine to receive, which gives a byte period of 19 clocks.
- R7: An asserted `rst_ni` (low) clears the state, the counters, the shift registers and the history. `ser_o` and `done_o` are low while it is asserted.
- R8: While `en_i` is low, `ser_o` and `done_o` are low, the machine sits in idle and any partial byte is discarded. The first edge with `en_i` high moves it to receive.
- R9: `ser_i` has no effect outside receive, and `ser_o` is low outside transmit.
- R10: `pad_o` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pipeline enable |
| ser_i | input | 1 | Serial data in, LSB first |
| ser_o | output | 1 | Serial masked data out, MSB first |
| done_o | output | 1 | One-clock strobe after each transmitted byte |
| pad_o | output | 6 | Unused output bits, tied low |

## Verification
A faulty history tap shows no symptom on the byte that corrupts it. It shows up as a wrong serial word one, two or three bytes later. For this reason every byte value is sent in sequence and compared with an arithmetic model that carries its own history. A wrong bit count or phase sequence shifts the whole frame: the `done_o` strobe moves off its 19-clock slot and `ser_o` bits land in the wrong positions within the same byte. Leaking enable or reset shows up when the outputs are sampled during the quiet windows and when the next byte is compared against a history the model kept or cleared.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned CW  = $clog2(DW);
  localparam int unsigned SW  = DW + 3;
  localparam int unsigned NT  = 3;
  localparam logic [DW-1:0] KEY = 8'hA5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_FIR, ST_ENC, ST_TX, ST_DONE
  } state_e;
endpackage

// File: rtl/sfx_rx.sv
module sfx_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] sh_q;

  // LSB first: newest bit enters at the top, first bit ends in bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (shift_i) sh_q <= {bit_i, sh_q[DW-1:1]};
  end

  assign data_o = sh_q;
endmodule

// File: rtl/sfx_fir.sv
module sfx_fir #(
  parameter int unsigned DW = 8,
  parameter int unsigned SW = DW + 3,
  parameter int unsigned NT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] y_o
);
  logic [DW-1:0] tap_q [NT];
  logic [DW-1:0] y_q;
  logic [SW-1:0] sum;

  // 1-2-2-1 weights on new sample and old taps
  assign sum = SW'(x_i) + (SW'(tap_q[0]) << 1) + (SW'(tap_q[1]) << 1) + SW'(tap_q[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= '0;
      for (int i = 0; i < NT; i++) tap_q[i] <= '0;
    end else if (step_i) begin
      y_q      <= sum[DW+1:2];
      tap_q[0] <= x_i;
      for (int i = 1; i < NT; i++) tap_q[i] <= tap_q[i-1];
    end
  end

  assign y_o = y_q;
endmodule

// File: rtl/sfx_tx.sv
module sfx_tx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [DW-1:0] data_i,
  output logic          msb_o
);
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[DW-2:0], 1'b0};
  end

  assign msb_o = sh_q[DW-1];
endmodule

// File: rtl/ser_fir_xor_pipe.sv
module ser_fir_xor_pipe
  import sfx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       ser_i,
  output logic       ser_o,
  output logic       done_o,
  output logic [5:0] pad_o
);
  state_e        state_q;
  logic [CW-1:0] cnt_q;
  logic          last_bit;
  logic [DW-1:0] rx_data, fir_y;
  logic          tx_msb;

  assign last_bit = (cnt_q == CW'(DW-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_RX;
          cnt_q   <= '0;
        end
        ST_RX: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) begin
            state_q <= ST_FIR;
            cnt_q   <= '0;
          end
        end
        ST_FIR: state_q <= ST_ENC;
        ST_ENC: begin
          state_q <= ST_TX;
          cnt_q   <= '0;
        end
        ST_TX: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) begin
            state_q <= ST_DONE;
            cnt_q   <= '0;
          end
        end
        ST_DONE: state_q <= ST_RX;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sfx_rx #(.DW(DW)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .shift_i (en_i && state_q == ST_RX),
    .bit_i   (ser_i),
    .data_o  (rx_data)
  );

  sfx_fir #(.DW(DW), .SW(SW), .NT(NT)) u_fir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (en_i && state_q == ST_FIR),
    .x_i    (rx_data),
    .y_o    (fir_y)
  );

  sfx_tx #(.DW(DW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!en_i),
    .load_i  (en_i && state_q == ST_ENC),
    .shift_i (en_i && state_q == ST_TX),
    .data_i  (fir_y ^ KEY),
    .msb_o   (tx_msb)
  );

  assign ser_o  = en_i && (state_q == ST_TX) && tx_msb;
  assign done_o = en_i && (state_q == ST_DONE);
  assign pad_o  = '0;
endmodule

// File: rtl/sfx_pipe_chk.sv
module sfx_pipe_chk
  import sfx_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          ser_o,
  input logic          done_o,
  input state_e        state_i,
  input logic [CW-1:0] cnt_i
);
  AST_RX_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FIR) |-> ($past(state_i) == ST_RX && $past(cnt_i) == CW'(DW-1))); // R1
  AST_ENC_AFTER_FIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ENC) |-> ($past(state_i) == ST_FIR)); // R4
  AST_DONE_AFTER_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(state_i) == ST_TX && $past(cnt_i) == CW'(DW-1))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!ser_o && !done_o)); // R8
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_i == ST_IDLE)); // R8
  AST_SER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_TX) |-> !ser_o); // R9
endmodule

bind ser_fir_xor_pipe sfx_pipe_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .ser_o   (ser_o),
  .done_o  (done_o),
  .state_i (state_q),
  .cnt_i   (cnt_q)
);

// File: tb/ser_fir_xor_pipe_tb.sv
`timescale 1ns/1ps
module ser_fir_xor_pipe_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic sin = 1'b0;
  logic sout, done;
  logic [5:0] pad;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] m0 = 8'h00, m1 = 8'h00, m2 = 8'h00;

  always #5 clk = ~clk;

  ser_fir_xor_pipe u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ser_i(sin),
    .ser_o(sout), .done_o(done), .pad_o(pad)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // arithmetic model: filter, mask, advance history
  task automatic model(input logic [7:0] b, output logic [7:0] e);
    int s;
    s = int'(b) + 2*int'(m0) + 2*int'(m1) + int'(m2);
    e = 8'((s >> 2) & 255) ^ 8'hA5;
    m2 = m1; m1 = m0; m0 = b;
  endtask

  task automatic rx_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) chk("R6 done low after strobe", int'(done), 0);
      chk("R9 ser_o low in receive", int'(sout), 0);
      sin = b[i];
      @(posedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] got);
    rx_bits(b, 8);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 ser_o low in filter/mask", int'(sout), 0);
      sin = ~sin;
      @(posedge clk);
    end
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      got[i] = sout;
      chk("R6 done low in transmit", int'(done), 0);
      sin = i[0];
      @(posedge clk);
    end
    @(negedge clk);
    chk("R6 done strobe", int'(done), 1);
    chk("R9 ser_o low in done", int'(sout), 0);
    sin = 1'b1;
    @(posedge clk);
  endtask

  task automatic run_byte(input logic [7:0] b, input string tag);
    logic [7:0] got, exp;
    model(b, exp);
    send_byte(b, got);
    chk(tag, int'(got), int'(exp));
  endtask

  task automatic quiet_window(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      sin = ~sin;
      chk(tag, int'({sout, done}), 0);
    end
  endtask

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    chk("R7 outputs low in reset", int'({sout, done}), 0);
    chk("R10 pad zero", int'(pad), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 quiet while disabled", int'({sout, done}), 0);
    en = 1'b1;
    @(posedge clk);

    run_byte(8'h80, "R3 first byte against zero history");
    run_byte(8'h80, "R3 second byte");
    for (int v = 0; v < 256; v++)
      run_byte(8'((v * 73 + 5) & 255), "R1 R2 R4 R5 sweep");
    for (int k = 0; k < 4; k++) run_byte(8'hFF, "R2 saturating sum truncation");
    chk("R10 pad zero in run", int'(pad), 0);
    for (int k = 0; k < 4; k++) run_byte(8'h00, "R2 zero drain");

    // abort during receive: partial byte discarded, history untouched
    rx_bits(8'hF0, 4);
    @(negedge clk); en = 1'b0;
    quiet_window("R8 quiet after abort in receive");
    en = 1'b1;
    @(posedge clk);
    run_byte(8'h3C, "R8 partial byte discarded");

    // abort during transmit: history already advanced and kept
    rx_bits(8'hC3, 8);
    model(8'hC3, exp);
    repeat (5) @(posedge clk);
    @(negedge clk); en = 1'b0;
    #1 chk("R8 outputs forced low at once", int'({sout, done}), 0);
    quiet_window("R8 quiet after abort in transmit");
    en = 1'b1;
    @(posedge clk);
    run_byte(8'h5A, "R3 history kept across enable low");
    run_byte(8'h99, "R3 history follow-on");

    // reset mid-run clears history
    rx_bits(8'h77, 5);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R7 outputs low in reset", int'({sout, done}), 0);
    m0 = 8'h00; m1 = 8'h00; m2 = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    run_byte(8'hE4, "R7 history cleared by reset");
    run_byte(8'h1B, "R7 after reset second byte");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule